// File: doc/BRIEF.md
# Banked Memory Crossbar Switch

This block is a single-stage switch between a set of request masters and a set of memory banks. Each master offers one single-word access: an address, write data and a write flag. The bank is chosen from the low bits of the address, which interleaves consecutive words across the banks. When several masters want the same bank in the same cycle, a per-bank round-robin arbiter admits one of them. Every forwarded request carries the index of the master that issued it.

Read data comes back over a second, independent network that has the same structure. A bank returns its word together with the master index it was given. That network routes the word to the right master, and uses round-robin arbitration where two banks answer the same master at once. A compile-time switch places a two-entry elastic stage on every output of both networks. The stage sits after decode and arbitration, so no combinational path runs through the switch. With the switch off, both networks are purely combinational. The switch does not order transactions across banks; the masters handle that.

Top module: `bankXbar`

## Requirements
- R1: After reset no slave request valid and no master response valid is asserted.
- R2: A request goes only to the slave whose index equals the address bits [log2(NUM_SLAVES)-1:0], with address, write data and write flag unchanged.
- R3: The tag on a forwarded request equals the index of the master that issued it.
- R4: Each output accepts at most one master per cycle. Among contending masters, the next grant goes to the first requesting master after the last one accepted, in ascending cyclic index order.
- R5: Under backpressure, every accepted request reaches its slave exactly once and in acceptance order. A refused master holds its request until it is accepted.
- R6: With ELASTIC=1, an accepted request appears at the slave in the next cycle. While the slave is not ready, the request stays valid and stable. A stalled output absorbs two requests and then refuses further ones.
- R7: A single master can stream to a free slave at one accepted request per cycle.
- R8: With ELASTIC=0, a lone request appears at its slave in the same cycle, and the master's ready equals that slave's ready.
- R9: A response reaches only the master named by its tag, with its read data unchanged. The response path follows the same latency rule as the request path.
- R10: When two slaves answer one master in the same cycle, only one is accepted per cycle, and both words are delivered in acceptance order.
- R11: Masters aimed at different slaves are all accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReqValid | input | NUM_MASTERS | Master request valid |
| mReqReady | output | NUM_MASTERS | Master request accepted |
| mReqAddr | input | NUM_MASTERS*ADDR_W | Master word addresses |
| mReqWdata | input | NUM_MASTERS*DATA_W | Master write data |
| mReqWe | input | NUM_MASTERS | Master write flag |
| sReqValid | output | NUM_SLAVES | Request valid toward each bank |
| sReqReady | input | NUM_SLAVES | Bank accepts request |
| sReqAddr | output | NUM_SLAVES*ADDR_W | Forwarded address |
| sReqWdata | output | NUM_SLAVES*DATA_W | Forwarded write data |
| sReqWe | output | NUM_SLAVES | Forwarded write flag |
| sReqTag | output | NUM_SLAVES*TAG_W | Index of the issuing master |
| sRspValid | input | NUM_SLAVES | Bank response valid |
| sRspReady | output | NUM_SLAVES | Response accepted by switch |
| sRspRdata | input | NUM_SLAVES*DATA_W | Bank read data |
| sRspTag | input | NUM_SLAVES*TAG_W | Destination master of the response |
| mRspValid | output | NUM_MASTERS | Response valid toward each master |
| mRspReady | input | NUM_MASTERS | Master accepts response |
| mRspRdata | output | NUM_MASTERS*DATA_W | Read data toward each master |

## Verification
With the elastic stage in place, a master's ready is due in the same cycle it presents a request, and the forwarded request is due one cycle after acceptance; responses follow the same pattern. The bench drives on the falling edge and samples one time unit later. It reads ready in the presenting cycle and slave outputs in the following one. A second, combinational instance shares the same inputs and is checked within the presenting cycle. For stall and contention runs, the bench records which transfers are accepted in each cycle and compares the deliveries one cycle later against that record.

// File: rtl/xbarPkg.sv
package xbarPkg;
  // Widest port index the strobes can carry (up to 256 ports per side).
  localparam int unsigned MaxIdxW = 8;

  // Per-output strobe from arbitration control to the datapath.
  typedef struct packed {
    logic               req;  // some input is granted on this output
    logic [MaxIdxW-1:0] sel;  // index of the granted input
  } routeStrobeT;
endpackage

// File: rtl/xbarSkid.sv
module xbarSkid #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [WIDTH-1:0] outData
);
  logic             skidValid;
  logic [WIDTH-1:0] skidData;

  // Ready depends only on local state, never on outReady.
  assign inReady = ~skidValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      skidValid <= 1'b0;
      skidData  <= '0;
    end else if (!outValid || outReady) begin
      if (skidValid) begin
        outValid  <= 1'b1;
        outData   <= skidData;
        skidValid <= 1'b0;
      end else begin
        outValid <= inValid;
        if (inValid) outData <= inData;
      end
    end else if (inValid && !skidValid) begin
      skidValid <= 1'b1;
      skidData  <= inData;
    end
  end
endmodule

// File: rtl/xbarArbCtrl.sv
module xbarArbCtrl
  import xbarPkg::*;
#(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned DEST_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*DEST_W-1:0] inDest,
  input  logic [NUM_OUT-1:0]       stageReady,
  output routeStrobeT [NUM_OUT-1:0] strobe,
  output logic [NUM_IN-1:0]        inReady
);
  localparam int unsigned IDX_W = $clog2(NUM_IN);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_IN-1:0] cand;
    logic [IDX_W-1:0]  ptr;
    logic [IDX_W-1:0]  pick;
    logic              found;

    always_comb begin
      for (int i = 0; i < NUM_IN; i++)
        cand[i] = inValid[i] && (inDest[i*DEST_W +: DEST_W] == DEST_W'(o));
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < NUM_IN; k++) begin
        if (!found && cand[(int'(ptr) + k) % NUM_IN]) begin
          found = 1'b1;
          pick  = IDX_W'((int'(ptr) + k) % NUM_IN);
        end
      end
    end

    // Pointer moves past the winner only when the grant is taken.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptr <= '0;
      else if (found && stageReady[o])
        ptr <= (pick == IDX_W'(NUM_IN - 1)) ? '0 : pick + 1'b1;
    end

    assign strobe[o] = routeStrobeT'{req: found, sel: MaxIdxW'(pick)};
  end

  always_comb begin
    inReady = '0;
    for (int o = 0; o < NUM_OUT; o++)
      if (strobe[o].req && stageReady[o]) inReady[strobe[o].sel[IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/xbarDatapath.sv
module xbarDatapath
  import xbarPkg::*;
#(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned PAY_W   = 8,
  parameter bit          ELASTIC = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN*PAY_W-1:0]   inPayload,
  input  routeStrobeT [NUM_OUT-1:0] strobe,
  output logic [NUM_OUT-1:0]        stageReady,
  output logic [NUM_OUT-1:0]        outValid,
  input  logic [NUM_OUT-1:0]        outReady,
  output logic [NUM_OUT*PAY_W-1:0]  outPayload
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [PAY_W-1:0] muxed;
    always_comb muxed = inPayload[int'(strobe[o].sel)*PAY_W +: PAY_W];

    if (ELASTIC) begin : g_elastic
      xbarSkid #(.WIDTH(PAY_W)) u_skid (
        .clk      (clk),
        .rstN     (rstN),
        .inValid  (strobe[o].req),
        .inReady  (stageReady[o]),
        .inData   (muxed),
        .outValid (outValid[o]),
        .outReady (outReady[o]),
        .outData  (outPayload[o*PAY_W +: PAY_W])
      );
    end else begin : g_direct
      assign outValid[o]                  = strobe[o].req;
      assign stageReady[o]                = outReady[o];
      assign outPayload[o*PAY_W +: PAY_W] = muxed;
    end
  end
endmodule

// File: rtl/bankXbar.sv
module bankXbar
  import xbarPkg::*;
#(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned NUM_SLAVES  = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter bit          ELASTIC     = 1'b1,
  localparam int unsigned SEL_W      = $clog2(NUM_SLAVES),
  localparam int unsigned TAG_W      = $clog2(NUM_MASTERS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        mReqValid,
  output logic [NUM_MASTERS-1:0]        mReqReady,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mReqAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] mReqWdata,
  input  logic [NUM_MASTERS-1:0]        mReqWe,
  output logic [NUM_SLAVES-1:0]         sReqValid,
  input  logic [NUM_SLAVES-1:0]         sReqReady,
  output logic [NUM_SLAVES*ADDR_W-1:0]  sReqAddr,
  output logic [NUM_SLAVES*DATA_W-1:0]  sReqWdata,
  output logic [NUM_SLAVES-1:0]         sReqWe,
  output logic [NUM_SLAVES*TAG_W-1:0]   sReqTag,
  input  logic [NUM_SLAVES-1:0]         sRspValid,
  output logic [NUM_SLAVES-1:0]         sRspReady,
  input  logic [NUM_SLAVES*DATA_W-1:0]  sRspRdata,
  input  logic [NUM_SLAVES*TAG_W-1:0]   sRspTag,
  output logic [NUM_MASTERS-1:0]        mRspValid,
  input  logic [NUM_MASTERS-1:0]        mRspReady,
  output logic [NUM_MASTERS*DATA_W-1:0] mRspRdata
);
  // Request payload layout, LSB first: we, wdata, addr, tag.
  localparam int unsigned REQ_W   = TAG_W + ADDR_W + DATA_W + 1;
  localparam int unsigned OFF_WD  = 1;
  localparam int unsigned OFF_AD  = OFF_WD + DATA_W;
  localparam int unsigned OFF_TAG = OFF_AD + ADDR_W;

  logic [NUM_MASTERS*REQ_W-1:0] reqIn;
  logic [NUM_MASTERS*SEL_W-1:0] reqDest;
  logic [NUM_SLAVES*REQ_W-1:0]  reqOut;
  logic [NUM_SLAVES-1:0]        reqStageReady;
  routeStrobeT [NUM_SLAVES-1:0] reqStrobe;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign reqIn[m*REQ_W +: REQ_W] = {TAG_W'(m), mReqAddr[m*ADDR_W +: ADDR_W],
                                      mReqWdata[m*DATA_W +: DATA_W], mReqWe[m]};
    assign reqDest[m*SEL_W +: SEL_W] = mReqAddr[m*ADDR_W +: SEL_W];
  end

  xbarArbCtrl #(.NUM_IN(NUM_MASTERS), .NUM_OUT(NUM_SLAVES), .DEST_W(SEL_W)) u_reqCtrl (
    .clk(clk), .rstN(rstN), .inValid(mReqValid), .inDest(reqDest),
    .stageReady(reqStageReady), .strobe(reqStrobe), .inReady(mReqReady)
  );

  xbarDatapath #(.NUM_IN(NUM_MASTERS), .NUM_OUT(NUM_SLAVES), .PAY_W(REQ_W),
                 .ELASTIC(ELASTIC)) u_reqData (
    .clk(clk), .rstN(rstN), .inPayload(reqIn), .strobe(reqStrobe),
    .stageReady(reqStageReady), .outValid(sReqValid), .outReady(sReqReady),
    .outPayload(reqOut)
  );

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slv
    assign sReqWe[s]                    = reqOut[s*REQ_W];
    assign sReqWdata[s*DATA_W +: DATA_W] = reqOut[s*REQ_W + OFF_WD +: DATA_W];
    assign sReqAddr[s*ADDR_W +: ADDR_W]  = reqOut[s*REQ_W + OFF_AD +: ADDR_W];
    assign sReqTag[s*TAG_W +: TAG_W]     = reqOut[s*REQ_W + OFF_TAG +: TAG_W];
  end

  // Response network: same control and datapath, routed by the tag.
  logic [NUM_MASTERS-1:0]        rspStageReady;
  routeStrobeT [NUM_MASTERS-1:0] rspStrobe;

  xbarArbCtrl #(.NUM_IN(NUM_SLAVES), .NUM_OUT(NUM_MASTERS), .DEST_W(TAG_W)) u_rspCtrl (
    .clk(clk), .rstN(rstN), .inValid(sRspValid), .inDest(sRspTag),
    .stageReady(rspStageReady), .strobe(rspStrobe), .inReady(sRspReady)
  );

  xbarDatapath #(.NUM_IN(NUM_SLAVES), .NUM_OUT(NUM_MASTERS), .PAY_W(DATA_W),
                 .ELASTIC(ELASTIC)) u_rspData (
    .clk(clk), .rstN(rstN), .inPayload(sRspRdata), .strobe(rspStrobe),
    .stageReady(rspStageReady), .outValid(mRspValid), .outReady(mRspReady),
    .outPayload(mRspRdata)
  );
endmodule

// File: rtl/bankXbarChk.sv
module bankXbarChk #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned NUM_SLAVES  = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter bit          ELASTIC     = 1'b1,
  localparam int unsigned SEL_W      = $clog2(NUM_SLAVES),
  localparam int unsigned TAG_W      = $clog2(NUM_MASTERS)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_MASTERS-1:0]        mReqValid,
  input logic [NUM_MASTERS-1:0]        mReqReady,
  input logic [NUM_MASTERS*ADDR_W-1:0] mReqAddr,
  input logic [NUM_SLAVES-1:0]         sReqValid,
  input logic [NUM_SLAVES-1:0]         sReqReady,
  input logic [NUM_SLAVES*ADDR_W-1:0]  sReqAddr,
  input logic [NUM_SLAVES*DATA_W-1:0]  sReqWdata,
  input logic [NUM_SLAVES*TAG_W-1:0]   sReqTag,
  input logic [NUM_SLAVES-1:0]         sRspValid,
  input logic [NUM_SLAVES-1:0]         sRspReady,
  input logic [NUM_SLAVES*TAG_W-1:0]   sRspTag,
  input logic [NUM_MASTERS-1:0]        mRspValid,
  input logic [NUM_MASTERS-1:0]        mRspReady,
  input logic [NUM_MASTERS*DATA_W-1:0] mRspRdata
);
  logic [NUM_SLAVES-1:0][NUM_MASTERS-1:0] reqTake;
  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] rspTake;

  always_comb begin
    for (int s = 0; s < NUM_SLAVES; s++)
      for (int m = 0; m < NUM_MASTERS; m++) begin
        reqTake[s][m] = mReqValid[m] && mReqReady[m] &&
                        (mReqAddr[m*ADDR_W +: SEL_W] == SEL_W'(s));
        rspTake[m][s] = sRspValid[s] && sRspReady[s] &&
                        (sRspTag[s*TAG_W +: TAG_W] == TAG_W'(m));
      end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sReqValid == '0 && mRspValid == '0));

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slv
    assert_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
      sReqValid[s] |-> (sReqAddr[s*ADDR_W +: SEL_W] == SEL_W'(s)));

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(reqTake[s]));

    if (ELASTIC) begin : g_hold
      assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
        (sReqValid[s] && !sReqReady[s]) |=>
          (sReqValid[s] && $stable(sReqAddr[s*ADDR_W +: ADDR_W]) &&
           $stable(sReqWdata[s*DATA_W +: DATA_W]) && $stable(sReqTag[s*TAG_W +: TAG_W])));
    end
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assert_rsp_one_R10: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(rspTake[m]));

    if (ELASTIC) begin : g_hold
      assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        (mRspValid[m] && !mRspReady[m]) |=>
          (mRspValid[m] && $stable(mRspRdata[m*DATA_W +: DATA_W])));
    end
  end
endmodule

bind bankXbar bankXbarChk #(
  .NUM_MASTERS(NUM_MASTERS), .NUM_SLAVES(NUM_SLAVES), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .ELASTIC(ELASTIC)
) i_bankXbarChk (
  .clk(clk), .rstN(rstN), .mReqValid(mReqValid), .mReqReady(mReqReady),
  .mReqAddr(mReqAddr), .sReqValid(sReqValid), .sReqReady(sReqReady),
  .sReqAddr(sReqAddr), .sReqWdata(sReqWdata), .sReqTag(sReqTag),
  .sRspValid(sRspValid), .sRspReady(sRspReady), .sRspTag(sRspTag),
  .mRspValid(mRspValid), .mRspReady(mRspReady), .mRspRdata(mRspRdata)
);

// File: tb/test_bankXbar.sv
module test_bankXbar;
  localparam int M = 4, N = 4, AW = 16, DW = 32, TW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic [M-1:0] mReqValid = '0, mReqWe = '0, mRspReady = '1;
  logic [M*AW-1:0] mReqAddr = '0;
  logic [M*DW-1:0] mReqWdata = '0;
  logic [N-1:0] sReqReady = '1, sRspValid = '0;
  logic [N*DW-1:0] sRspRdata = '0;
  logic [N*TW-1:0] sRspTag = '0;

  logic [M-1:0] mReqReady, mRspValid, cMReqReady, cMRspValid;
  logic [N-1:0] sReqValid, sReqWe, sRspReady, cSReqValid, cSReqWe, cSRspReady;
  logic [N*AW-1:0] sReqAddr, cSReqAddr;
  logic [N*DW-1:0] sReqWdata, cSReqWdata;
  logic [N*TW-1:0] sReqTag, cSReqTag;
  logic [M*DW-1:0] mRspRdata, cMRspRdata;

  bankXbar #(.NUM_MASTERS(M), .NUM_SLAVES(N), .ADDR_W(AW), .DATA_W(DW), .ELASTIC(1'b1)) i_bankXbar (
    .clk(clk), .rstN(rstN), .mReqValid(mReqValid), .mReqReady(mReqReady), .mReqAddr(mReqAddr),
    .mReqWdata(mReqWdata), .mReqWe(mReqWe), .sReqValid(sReqValid), .sReqReady(sReqReady),
    .sReqAddr(sReqAddr), .sReqWdata(sReqWdata), .sReqWe(sReqWe), .sReqTag(sReqTag),
    .sRspValid(sRspValid), .sRspReady(sRspReady), .sRspRdata(sRspRdata), .sRspTag(sRspTag),
    .mRspValid(mRspValid), .mRspReady(mRspReady), .mRspRdata(mRspRdata));

  bankXbar #(.NUM_MASTERS(M), .NUM_SLAVES(N), .ADDR_W(AW), .DATA_W(DW), .ELASTIC(1'b0)) i_bankXbarComb (
    .clk(clk), .rstN(rstN), .mReqValid(mReqValid), .mReqReady(cMReqReady), .mReqAddr(mReqAddr),
    .mReqWdata(mReqWdata), .mReqWe(mReqWe), .sReqValid(cSReqValid), .sReqReady(sReqReady),
    .sReqAddr(cSReqAddr), .sReqWdata(cSReqWdata), .sReqWe(cSReqWe), .sReqTag(cSReqTag),
    .sRspValid(sRspValid), .sRspReady(cSRspReady), .sRspRdata(sRspRdata), .sRspTag(sRspTag),
    .mRspValid(cMRspValid), .mRspReady(mRspReady), .mRspRdata(cMRspRdata));

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle(input int n);
    mReqValid = '0; sRspValid = '0;
    repeat (n) tick();
  endtask

  task automatic setReq(input int m, input logic [15:0] a, input logic [31:0] d, input bit we);
    mReqAddr[m*AW +: AW] = a; mReqWdata[m*DW +: DW] = d; mReqWe[m] = we;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tick(); rstN = 1'b1;
    settle();
    // R1: nothing valid after reset
    chk(sReqValid == '0 && cSReqValid == '0, "R1 req idle", 64'(sReqValid), 0);
    chk(mRspValid == '0 && cMRspValid == '0, "R1 rsp idle", 64'(mRspValid), 0);

    // Decode sweep: every master to every slave, alone.
    for (int m = 0; m < M; m++)
      for (int s = 0; s < N; s++) begin
        logic [15:0] a;
        logic [31:0] d;
        a = 16'(((m * 4 + s + 1) * 64) + s);
        d = 32'hA000_0000 + 32'(m * 256 + s);
        tick();
        setReq(m, a, d, bit'((m + s) % 2)); mReqValid = '0; mReqValid[m] = 1'b1;
        settle();
        chk(mReqReady[m] == 1'b1, "R6 ready in presenting cycle", 64'(mReqReady), 64'(1 << m));
        // R8: combinational variant shows the request now
        chk(cSReqValid == 4'(1 << s) && cSReqAddr[s*AW +: AW] == a, "R8 same-cycle forward",
            64'(cSReqValid), 64'(1 << s));
        tick(); mReqValid = '0; settle();
        chk(sReqValid == 4'(1 << s), "R2 decode to slave", 64'(sReqValid), 64'(1 << s));
        chk(sReqAddr[s*AW +: AW] == a && sReqWdata[s*DW +: DW] == d && sReqWe[s] == bit'((m + s) % 2),
            "R2 fields intact", 64'(sReqWdata[s*DW +: DW]), 64'(d));
        chk(sReqTag[s*TW +: TW] == 2'(m), "R3 master tag", 64'(sReqTag[s*TW +: TW]), 64'(m));
      end
    idle(2);

    // R11: four masters to four different slaves at once.
    tick();
    for (int m = 0; m < M; m++) setReq(m, 16'(16'h0100 * m + (m + 1) % N), 32'(m), 1'b0);
    mReqValid = '1; settle();
    chk(mReqReady == '1, "R11 parallel accept", 64'(mReqReady), 64'hF);
    tick(); mReqValid = '0; settle();
    chk(sReqValid == '1, "R11 parallel deliver", 64'(sReqValid), 64'hF);
    for (int s = 0; s < N; s++)
      chk(sReqTag[s*TW +: TW] == 2'((s + N - 1) % N), "R3 tag per slave",
          64'(sReqTag[s*TW +: TW]), 64'((s + N - 1) % N));
    idle(2);

    // R4: all masters contend for slave 2, two requests each.
    begin
      int pend[M];
      int prev;
      prev = -1;
      for (int m = 0; m < M; m++) begin pend[m] = 2; setReq(m, 16'h0042 + 16'(m * 16'h100), 32'(m), 1'b1); end
      for (int c = 0; c < 2 * M; c++) begin
        int g;
        tick();
        for (int m = 0; m < M; m++) mReqValid[m] = (pend[m] > 0);
        settle();
        chk($countones(mReqReady & mReqValid) == 1, "R4 one grant", 64'(mReqReady), 1);
        g = 0;
        for (int m = 0; m < M; m++) if (mReqReady[m] && mReqValid[m]) g = m;
        if (prev >= 0) chk(g == (prev + 1) % M, "R4 cyclic order", 64'(g), 64'((prev + 1) % M));
        prev = g; pend[g]--;
      end
      idle(3);
    end

    // R5/R6/R8: stalled slave 1, master 0 sends three words.
    begin
      logic [31:0] w[3];
      int k, nGot;
      logic [3:0] rdyPat;
      w[0] = 32'h1111_0001; w[1] = 32'h2222_0002; w[2] = 32'h3333_0003;
      k = 0; nGot = 0; rdyPat = '0;
      sReqReady[1] = 1'b0;
      for (int c = 0; c < 4; c++) begin
        tick();
        setReq(0, 16'h0501, w[k], 1'b1); mReqValid = 4'b0001; settle();
        if (c == 0) chk(cMReqReady[0] == 1'b0, "R8 ready follows slave", 64'(cMReqReady[0]), 0);
        rdyPat[c] = mReqReady[0];
        if (mReqReady[0]) k++;
      end
      chk(rdyPat == 4'b0011, "R6 absorbs two then refuses", 64'(rdyPat), 64'h3);
      chk(sReqValid[1] && sReqWdata[1*DW +: DW] == w[0], "R6 stalled output holds", 64'(sReqWdata[1*DW +: DW]), 64'(w[0]));
      tick(); sReqReady[1] = 1'b1;
      for (int c = 0; c < 5; c++) begin
        if (k < 3) begin setReq(0, 16'h0501, w[k], 1'b1); mReqValid = 4'b0001; end
        else mReqValid = '0;
        settle();
        if (sReqValid[1]) begin
          if (nGot < 3) chk(sReqWdata[1*DW +: DW] == w[nGot], "R5 in-order delivery",
                            64'(sReqWdata[1*DW +: DW]), 64'(w[nGot]));
          nGot++;
        end
        if (mReqValid[0] && mReqReady[0]) k++;
        tick();
      end
      chk(nGot == 3, "R5 exactly once", 64'(nGot), 3);
      idle(2);
    end

    // R7: master 3 streams eight words to slave 0.
    for (int c = 0; c <= 8; c++) begin
      tick();
      if (c < 8) begin setReq(3, 16'h0700 + 16'(c * 4), 32'hB000_0000 + 32'(c), 1'b1); mReqValid = 4'b1000; end
      else mReqValid = '0;
      settle();
      if (c < 8) chk(mReqReady[3] == 1'b1, "R7 accept every cycle", 64'(mReqReady), 64'h8);
      if (c > 0) chk(sReqValid[0] && sReqWdata[0 +: DW] == 32'hB000_0000 + 32'(c - 1),
                     "R7 back-to-back delivery", 64'(sReqWdata[0 +: DW]), 64'(32'hB000_0000 + 32'(c - 1)));
    end
    idle(2);

    // R9: response sweep, every slave to every master.
    for (int s = 0; s < N; s++)
      for (int m = 0; m < M; m++) begin
        logic [31:0] d;
        d = 32'hC0DE_0000 + 32'(s * 16 + m);
        tick();
        sRspValid = '0; sRspValid[s] = 1'b1;
        sRspTag[s*TW +: TW] = 2'(m); sRspRdata[s*DW +: DW] = d;
        settle();
        chk(sRspReady[s] == 1'b1, "R9 response accepted", 64'(sRspReady), 64'(1 << s));
        chk(cMRspValid == 4'(1 << m) && cMRspRdata[m*DW +: DW] == d, "R8 same-cycle response",
            64'(cMRspValid), 64'(1 << m));
        tick(); sRspValid = '0; settle();
        chk(mRspValid == 4'(1 << m) && mRspRdata[m*DW +: DW] == d, "R9 routed by tag",
            64'(mRspRdata[m*DW +: DW]), 64'(d));
      end
    idle(2);

    // R10: slaves 0 and 3 answer master 1 together.
    begin
      int first, second;
      logic [31:0] dA, dB;
      dA = 32'hD000_000A; dB = 32'hD000_000B;
      tick();
      sRspTag[0 +: TW] = 2'd1; sRspRdata[0 +: DW] = dA;
      sRspTag[3*TW +: TW] = 2'd1; sRspRdata[3*DW +: DW] = dB;
      sRspValid = 4'b1001; settle();
      chk($countones(sRspReady & sRspValid) == 1, "R10 one response per cycle", 64'(sRspReady), 1);
      first = sRspReady[0] ? 0 : 3; second = 3 - first;
      tick(); sRspValid[first] = 1'b0; settle();
      chk(mRspValid[1] && mRspRdata[1*DW +: DW] == (first == 0 ? dA : dB), "R10 first word",
          64'(mRspRdata[1*DW +: DW]), 64'(first == 0 ? dA : dB));
      chk(sRspReady[second] == 1'b1, "R10 second accepted next", 64'(sRspReady), 64'(1 << second));
      tick(); sRspValid = '0; settle();
      chk(mRspValid[1] && mRspRdata[1*DW +: DW] == (second == 0 ? dA : dB), "R10 second word",
          64'(mRspRdata[1*DW +: DW]), 64'(second == 0 ? dA : dB));
      idle(2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule